// File: doc/BRIEF.md
# Memory-Scanning CRC-32 Checker

This block is a small bus master that walks a region of memory and folds every unit it fetches into a running CRC-32. Configuration reaches it as plain level inputs: a start address, a unit count, an access width, a throttle divider, a compare enable, a reference value and an interrupt mask. Starting takes two separate actions. The engine enable input must already be high. A fetch-start pulse then launches the scan. The engine issues one single read at a time over a valid/ready request port and takes each result from a one-cycle response pulse. It updates the CRC, steps the address and counts down. When the count runs out it drops its fetch-active status by itself.

The CRC is not cleared between runs. Successive runs over separate regions therefore build one checksum, and a reset command sets it back to all ones. When compare mode is on, the CRC produced by the last fold of a run is checked against the reference. A mismatch sets a sticky error flag, and the interrupt output is that flag qualified by its mask.

Top module: `crc_scan_engine`

## Requirements
- R1: After reset, crc_value is 32'hFFFFFFFF. fetch_active, err_flag, irq and mem_req_valid are all 0.
- R2: A fetch_start pulse starts a run only when cfg_enable is 1, the engine is idle and cfg_count is nonzero. In every other case it has no effect, including a pulse that arrives while a run is in progress.
- R3: A run issues exactly cfg_count reads. The first read goes to cfg_base_addr. Width code 0 reads bytes and advances the address by 1, code 1 reads halfwords and advances by 2, and codes 2 and 3 read words and advance by 4. mem_req_size carries 0, 1 or 2 for these three cases.
- R4: Each response folds the low 8, 16 or 32 bits of mem_rsp_data into the CRC, least significant bit first, using the reflected form of polynomial 0x04C11DB7 with no final inversion. Upper bits are ignored. crc_value shows the new value in the cycle after the response.
- R5: fetch_active goes low in the cycle after the last response, and no request follows it. A start with a count of 0 leaves the engine idle.
- R6: With a latched divider D, the next request rises exactly D cycles after the cycle that follows the response.
- R7: A request keeps its valid, address and size unchanged until it is accepted. No new request is raised while a read is outstanding.
- R8: A crc_reset pulse sets crc_value to 32'hFFFFFFFF. If the pulse coincides with a response, that unit is folded into all ones.
- R9: A later run started without crc_reset continues from the CRC left by the previous run.
- R10: When cmp_enable is 1 at the last fold of a run, a CRC that differs from cmp_ref sets err_flag. A CRC that matches leaves err_flag unchanged.
- R11: err_flag holds until an err_clear pulse. If a set and a clear fall in the same cycle, the set wins. irq is high only when both err_flag and err_mask are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Engine enable; must be 1 for a start to be accepted |
| fetch_start | input | 1 | Single-cycle pulse that launches a run |
| cfg_base_addr | input | ADDR_W | Byte address of the first unit |
| cfg_count | input | COUNT_W | Number of units to read |
| cfg_width | input | 2 | Access width code: 0 byte, 1 halfword, 2 or 3 word |
| cfg_divider | input | DIV_W | Minimum number of idle cycles between accesses |
| cmp_enable | input | 1 | Check the final CRC against cmp_ref |
| cmp_ref | input | 32 | Reference CRC |
| crc_reset | input | 1 | Pulse that sets the CRC to all ones |
| err_clear | input | 1 | Pulse that clears err_flag |
| err_mask | input | 1 | 1 lets err_flag reach irq |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_req_size | output | 2 | Read size: 0 byte, 1 halfword, 2 word |
| mem_rsp_valid | input | 1 | One-cycle read data valid |
| mem_rsp_data | input | 32 | Read data, right-aligned |
| crc_value | output | 32 | Running CRC |
| fetch_active | output | 1 | A run is in progress |
| err_flag | output | 1 | Sticky compare-mismatch flag |
| irq | output | 1 | Masked error interrupt |

## Verification
A crc_reset pulse can arrive in the same cycle as a read response. Likewise, an err_clear pulse can meet the compare mismatch produced by the last fold. The bench raises crc_reset on the very cycle it drives the third response of one run. The expected result is the fold of that unit into all ones, and crc_value is compared against it one cycle later. In another run the bench drives err_clear together with the final response of a run whose reference is known to be wrong, and it expects err_flag to remain set.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   typedef enum logic [1:0] {
      UNIT_BYTE = 2'd0,
      UNIT_HALF = 2'd1,
      UNIT_WORD = 2'd2
   } unit_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_GAP  = 2'd3
   } seq_state_t;

   function automatic unit_t unit_of(input logic [1:0] code);
      case (code)
         2'd0:    unit_of = UNIT_BYTE;
         2'd1:    unit_of = UNIT_HALF;
         default: unit_of = UNIT_WORD;
      endcase
   endfunction

   function automatic logic [2:0] unit_bytes(input unit_t u);
      case (u)
         UNIT_BYTE: unit_bytes = 3'd1;
         UNIT_HALF: unit_bytes = 3'd2;
         default:   unit_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
   import crc_scan_pkg::*;
#(
   parameter logic [31:0] POLY = CRC_POLY_REFL,
   parameter int          DATA_W = 32
) (
   input  logic [31:0]       crc_in,
   input  logic [DATA_W-1:0] data_in,
   input  unit_t             unit,
   output logic [31:0]       crc_out
);
   localparam int STAGES = DATA_W;

   if (DATA_W != 32) begin : g_bad_width
      $error("crc_fold_unit: DATA_W must be 32");
   end

   logic [31:0] chain [0:STAGES];

   assign chain[0] = crc_in;

   for (genvar i = 0; i < STAGES; i++) begin : g_bit
      logic fb;
      assign fb = chain[i][0] ^ data_in[i];
      assign chain[i+1] = {1'b0, chain[i][31:1]} ^ (fb ? POLY : 32'd0);
   end

   always_comb begin
      case (unit)
         UNIT_BYTE: crc_out = chain[8];
         UNIT_HALF: crc_out = chain[16];
         default:   crc_out = chain[32];
      endcase
   end

endmodule

// File: rtl/access_pacer.sv
module access_pacer #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_val,
   output logic             expire
);
   if (DIV_W < 1) begin : g_bad_div
      $error("access_pacer: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= div_val;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign expire = (left_q == DIV_W'(1));

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
   import crc_scan_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int COUNT_W = 16,
   parameter int DIV_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               fetch_start,
   input  logic [ADDR_W-1:0]  cfg_base_addr,
   input  logic [COUNT_W-1:0] cfg_count,
   input  logic [1:0]         cfg_width,
   input  logic [DIV_W-1:0]   cfg_divider,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [1:0]         mem_req_size,
   input  logic               mem_rsp_valid,
   output logic               fold_en,
   output logic               fold_last,
   output unit_t              fold_unit,
   output logic               active
);
   seq_state_t         state_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [COUNT_W-1:0] left_q;
   unit_t              unit_q;
   logic [DIV_W-1:0]   div_q;
   logic               start_ok;
   logic               pace_load;
   logic               pace_expire;
   logic               final_unit;

   access_pacer #(.DIV_W(DIV_W)) pacer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pace_load),
      .div_val (div_q),
      .expire  (pace_expire)
   );

   assign start_ok   = fetch_start && cfg_enable && (state_q == SQ_IDLE) && (cfg_count != '0);
   assign final_unit = (left_q == COUNT_W'(1));
   assign fold_en    = (state_q == SQ_WAIT) && mem_rsp_valid;
   assign fold_last  = fold_en && final_unit;
   assign pace_load  = fold_en && !final_unit && (div_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         unit_q  <= UNIT_BYTE;
         div_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start_ok) begin
                  addr_q  <= cfg_base_addr;
                  left_q  <= cfg_count;
                  unit_q  <= unit_of(cfg_width);
                  div_q   <= cfg_divider;
                  state_q <= SQ_REQ;
               end
            end
            SQ_REQ: begin
               if (mem_req_ready) state_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (mem_rsp_valid) begin
                  addr_q <= addr_q + ADDR_W'(unit_bytes(unit_q));
                  left_q <= left_q - 1'b1;
                  if (final_unit)          state_q <= SQ_IDLE;
                  else if (div_q == '0)    state_q <= SQ_REQ;
                  else                     state_q <= SQ_GAP;
               end
            end
            SQ_GAP: begin
               if (pace_expire) state_q <= SQ_REQ;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == SQ_REQ);
   assign mem_req_addr  = addr_q;
   assign mem_req_size  = unit_q;
   assign fold_unit     = unit_q;
   assign active        = (state_q != SQ_IDLE);

endmodule

// File: rtl/crc_accum.sv
module crc_accum
   import crc_scan_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        crc_reset,
   input  logic        fold_en,
   input  logic        fold_last,
   input  unit_t       fold_unit,
   input  logic [31:0] fold_data,
   input  logic        cmp_enable,
   input  logic [31:0] cmp_ref,
   input  logic        err_clear,
   input  logic        err_mask,
   output logic [31:0] crc_value,
   output logic        err_flag,
   output logic        irq
);
   logic [31:0] crc_q;
   logic [31:0] crc_base;
   logic [31:0] crc_folded;
   logic        err_q;
   logic        err_set;

   assign crc_base = crc_reset ? CRC_SEED : crc_q;

   crc_fold_unit #(.POLY(CRC_POLY_REFL), .DATA_W(32)) fold_i (
      .crc_in  (crc_base),
      .data_in (fold_data),
      .unit    (fold_unit),
      .crc_out (crc_folded)
   );

   assign err_set = fold_last && cmp_enable && (crc_folded != cmp_ref);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= CRC_SEED;
         err_q <= 1'b0;
      end else begin
         crc_q <= fold_en ? crc_folded : crc_base;
         if (err_set)        err_q <= 1'b1;
         else if (err_clear) err_q <= 1'b0;
      end
   end

   assign crc_value = crc_q;
   assign err_flag  = err_q;
   assign irq       = err_q & err_mask;

endmodule

// File: rtl/crc_scan_engine.sv
module crc_scan_engine
   import crc_scan_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int COUNT_W = 16,
   parameter int DIV_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               fetch_start,
   input  logic [ADDR_W-1:0]  cfg_base_addr,
   input  logic [COUNT_W-1:0] cfg_count,
   input  logic [1:0]         cfg_width,
   input  logic [DIV_W-1:0]   cfg_divider,
   input  logic               cmp_enable,
   input  logic [31:0]        cmp_ref,
   input  logic               crc_reset,
   input  logic               err_clear,
   input  logic               err_mask,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [1:0]         mem_req_size,
   input  logic               mem_rsp_valid,
   input  logic [31:0]        mem_rsp_data,
   output logic [31:0]        crc_value,
   output logic               fetch_active,
   output logic               err_flag,
   output logic               irq
);
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
      $error("crc_scan_engine: ADDR_W out of range 2..64");
   end
   if (COUNT_W < 1) begin : g_bad_count
      $error("crc_scan_engine: COUNT_W must be at least 1");
   end

   logic  fold_en;
   logic  fold_last;
   unit_t fold_unit;

   fetch_sequencer #(
      .ADDR_W  (ADDR_W),
      .COUNT_W (COUNT_W),
      .DIV_W   (DIV_W)
   ) seq_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_enable    (cfg_enable),
      .fetch_start   (fetch_start),
      .cfg_base_addr (cfg_base_addr),
      .cfg_count     (cfg_count),
      .cfg_width     (cfg_width),
      .cfg_divider   (cfg_divider),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_req_size  (mem_req_size),
      .mem_rsp_valid (mem_rsp_valid),
      .fold_en       (fold_en),
      .fold_last     (fold_last),
      .fold_unit     (fold_unit),
      .active        (fetch_active)
   );

   crc_accum acc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .crc_reset  (crc_reset),
      .fold_en    (fold_en),
      .fold_last  (fold_last),
      .fold_unit  (fold_unit),
      .fold_data  (mem_rsp_data),
      .cmp_enable (cmp_enable),
      .cmp_ref    (cmp_ref),
      .err_clear  (err_clear),
      .err_mask   (err_mask),
      .crc_value  (crc_value),
      .err_flag   (err_flag),
      .irq        (irq)
   );

endmodule

// File: rtl/crc_scan_engine_chk.sv
module crc_scan_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic              fetch_start,
   input logic              crc_reset,
   input logic              err_clear,
   input logic              err_mask,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [1:0]        mem_req_size,
   input logic              mem_rsp_valid,
   input logic [31:0]       crc_value,
   input logic              fetch_active,
   input logic              err_flag,
   input logic              irq
);
   logic              pending_q;
   logic              have_prev_q;
   logic [ADDR_W-1:0] prev_addr_q;
   logic [1:0]        prev_size_q;
   logic              hs;
   logic [ADDR_W-1:0] step;

   assign hs   = mem_req_valid && mem_req_ready;
   assign step = (prev_size_q == 2'd0) ? ADDR_W'(1) :
                 (prev_size_q == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q   <= 1'b0;
         have_prev_q <= 1'b0;
         prev_addr_q <= '0;
         prev_size_q <= '0;
      end else begin
         if (hs)                 pending_q <= 1'b1;
         else if (mem_rsp_valid) pending_q <= 1'b0;
         if (!fetch_active) begin
            have_prev_q <= 1'b0;
         end else if (hs) begin
            have_prev_q <= 1'b1;
            prev_addr_q <= mem_req_addr;
            prev_size_q <= mem_req_size;
         end
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)); // R7
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q |-> !mem_req_valid); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_active |-> !mem_req_valid); // R5
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_active && !(fetch_start && cfg_enable) |=> !fetch_active); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      hs && have_prev_q |-> mem_req_addr == prev_addr_q + step); // R3
   AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      crc_reset && !mem_rsp_valid |=> crc_value == 32'hFFFF_FFFF); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !err_clear |=> err_flag); // R11
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !err_mask |-> !irq); // R11

endmodule

bind crc_scan_engine crc_scan_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_enable    (cfg_enable),
   .fetch_start   (fetch_start),
   .crc_reset     (crc_reset),
   .err_clear     (err_clear),
   .err_mask      (err_mask),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_size  (mem_req_size),
   .mem_rsp_valid (mem_rsp_valid),
   .crc_value     (crc_value),
   .fetch_active  (fetch_active),
   .err_flag      (err_flag),
   .irq           (irq)
);

// File: tb/crc_scan_engine_tb_top.sv
module crc_scan_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CW = 16;
   localparam int DW = 4;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          cfg_enable = 0;
   logic          fetch_start = 0;
   logic [AW-1:0] cfg_base_addr = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [1:0]    cfg_width = '0;
   logic [DW-1:0] cfg_divider = '0;
   logic          cmp_enable = 0;
   logic [31:0]   cmp_ref = '0;
   logic          crc_reset_t = 0, crc_reset_m = 0, crc_reset;
   logic          err_clear_t = 0, err_clear_m = 0, err_clear;
   logic          err_mask = 0;
   logic          mem_req_valid;
   logic          mem_req_ready = 0;
   logic [AW-1:0] mem_req_addr;
   logic [1:0]    mem_req_size;
   logic          mem_rsp_valid = 0;
   logic [31:0]   mem_rsp_data = '0;
   logic [31:0]   crc_value;
   logic          fetch_active, err_flag, irq;

   assign crc_reset = crc_reset_t | crc_reset_m;
   assign err_clear = err_clear_t | err_clear_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_scan_engine #(.ADDR_W(AW), .COUNT_W(CW), .DIV_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .fetch_start(fetch_start),
      .cfg_base_addr(cfg_base_addr), .cfg_count(cfg_count), .cfg_width(cfg_width),
      .cfg_divider(cfg_divider), .cmp_enable(cmp_enable), .cmp_ref(cmp_ref),
      .crc_reset(crc_reset), .err_clear(err_clear), .err_mask(err_mask),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .crc_value(crc_value), .fetch_active(fetch_active), .err_flag(err_flag), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit done = 0;

   // memory model state
   logic [31:0] model_crc = 32'hFFFF_FFFF;
   logic [AW-1:0] exp_addr, hs_addr;
   int  exp_bytes = 4, exp_size = 2, exp_div = 0, hs_bits = 32;
   bit  pending = 0, have_rsp = 0, req_prev = 0, clear_on_last = 0;
   int  lat = 0, rsp_cyc = 0, resp_count = 0, tgt_count = 0, rst_at_idx = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
      mem_word = (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ {a[15:0], a[31:16]};
   endfunction

   function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] d, input int nbits);
      logic [31:0] r = c;
      for (int i = 0; i < nbits; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic int bits_of(input logic [1:0] w);
      return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
   endfunction

   function automatic logic [31:0] predict(input logic [31:0] c, input logic [AW-1:0] base,
                                           input int cnt, input logic [1:0] w);
      logic [31:0] r = c;
      logic [AW-1:0] a = base;
      for (int i = 0; i < cnt; i++) begin
         r = ref_fold(r, mem_word(a), bits_of(w));
         a = a + AW'(bits_of(w) / 8);
      end
      return r;
   endfunction

   always @(posedge clk) cyc++;

   // memory responder, all activity at the falling edge
   always @(negedge clk) begin
      crc_reset_m   = 0;
      err_clear_m   = 0;
      mem_req_ready = 0;
      if (mem_rsp_valid) begin
         mem_rsp_valid = 0;
         chk(crc_value == model_crc, "R4 crc after fold", crc_value, model_crc);
      end
      if (pending) begin
         lat--;
         if (lat == 0) begin
            pending = 0;
            resp_count++;
            if (resp_count == rst_at_idx) begin
               crc_reset_m = 1;            // R8 reset coincident with response
               model_crc = 32'hFFFF_FFFF;
            end
            if (clear_on_last && resp_count == tgt_count) err_clear_m = 1; // R11
            model_crc     = ref_fold(model_crc, mem_word(hs_addr), hs_bits);
            mem_rsp_data  = mem_word(hs_addr);
            mem_rsp_valid = 1;
            rsp_cyc  = cyc + 1;
            have_rsp = 1;
         end
      end else if (mem_req_valid) begin
         if (!req_prev && have_rsp)
            chk(cyc - rsp_cyc == exp_div, "R6 request spacing", cyc - rsp_cyc, exp_div);
         if ($urandom % 4 != 0) begin
            mem_req_ready = 1;
            chk(mem_req_addr == exp_addr, "R3 request address", mem_req_addr, exp_addr);
            chk(mem_req_size == 2'(exp_size), "R3 request size", 32'(mem_req_size), exp_size);
            hs_addr  = mem_req_addr;
            hs_bits  = exp_bytes * 8;
            exp_addr = exp_addr + AW'(exp_bytes);
            pending  = 1;
            lat      = 1 + int'($urandom % 3);
         end
      end
      req_prev = mem_req_valid;
   end

   task automatic pulse_start();
      fetch_start = 1;
      @(negedge clk);
      fetch_start = 0;
   endtask

   task automatic run(input logic [AW-1:0] base, input int cnt, input logic [1:0] w,
                      input int div, input bit cmp_en, input logic [31:0] refv,
                      input bit restart_mid);
      logic [31:0] pred;
      @(negedge clk);
      pred          = predict(model_crc, base, cnt, w);
      cfg_enable    = 1;
      cfg_base_addr = base;
      cfg_count     = CW'(cnt);
      cfg_width     = w;
      cfg_divider   = DW'(div);
      cmp_enable    = cmp_en;
      cmp_ref       = refv;
      exp_addr      = base;
      exp_bytes     = bits_of(w) / 8;
      exp_size      = (w == 2'd3) ? 2 : int'(w);
      exp_div       = div;
      have_rsp      = 0;
      resp_count    = 0;
      tgt_count     = cnt;
      pulse_start();
      if (restart_mid) begin
         repeat (3) @(negedge clk);
         cfg_base_addr = base + 32'h100;
         cfg_count     = CW'(cnt + 5);
         pulse_start();                     // R2 ignored while active
      end
      while (fetch_active) @(negedge clk);
      @(negedge clk);
      chk(resp_count == cnt, "R3 R5 reads per run", resp_count, cnt);
      chk(!mem_req_valid && !fetch_active, "R5 idle after last read",
          {mem_req_valid, fetch_active}, 0);
      if (rst_at_idx == 0)
         chk(crc_value == pred, "R9 final crc continues from previous", crc_value, pred);
      rst_at_idx    = 0;
      clear_on_last = 0;
      cmp_enable    = 0;
   endtask

   initial begin
      logic [31:0] p;
      void'($urandom(32'd20240601));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(crc_value == 32'hFFFF_FFFF, "R1 crc at reset", crc_value, 32'hFFFF_FFFF);
      chk({fetch_active, err_flag, irq, mem_req_valid} == 0, "R1 flags at reset",
          {fetch_active, err_flag, irq, mem_req_valid}, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 start ignored with engine enable low
      cfg_enable = 0; cfg_count = 4; cfg_base_addr = 32'h40;
      pulse_start();
      for (int i = 0; i < 8; i++) begin
         chk(!fetch_active && !mem_req_valid, "R2 no start while disabled",
             {fetch_active, mem_req_valid}, 0);
         @(negedge clk);
      end

      // R5 start with zero count stays idle
      cfg_enable = 1; cfg_count = 0;
      pulse_start();
      repeat (2) @(negedge clk);
      chk(!fetch_active, "R5 zero count stays idle", fetch_active, 0);

      // random runs accumulating across regions (R3 R4 R6 R9)
      for (int r = 0; r < 30; r++) begin
         run(($urandom & 32'h00FF_FFF0), 1 + int'($urandom % 12), 2'($urandom % 4),
             int'($urandom % 4), 0, 0, 0);
      end

      // R8 reset command while idle
      @(negedge clk);
      crc_reset_t = 1;
      @(negedge clk);
      crc_reset_t = 0;
      model_crc = 32'hFFFF_FFFF;
      chk(crc_value == 32'hFFFF_FFFF, "R8 crc reset", crc_value, 32'hFFFF_FFFF);

      // R2 restart pulse during a run has no effect
      run(32'h1000, 8, 2'd1, 2, 0, 0, 1);

      // R8 reset coincident with third response
      rst_at_idx = 3;
      run(32'h2000, 6, 2'd2, 1, 0, 0, 0);

      // R10 matching compare leaves flag clear
      p = predict(model_crc, 32'h3000, 5, 2'd0);
      run(32'h3000, 5, 2'd0, 0, 1, p, 0);
      chk(!err_flag, "R10 match leaves flag clear", err_flag, 0);

      // R10 mismatch sets flag; R11 mask gating
      err_mask = 0;
      p = predict(model_crc, 32'h3100, 4, 2'd2);
      run(32'h3100, 4, 2'd2, 1, 1, ~p, 0);
      chk(err_flag, "R10 mismatch sets flag", err_flag, 1);
      chk(!irq, "R11 irq masked", irq, 0);
      err_mask = 1;
      @(negedge clk);
      chk(irq, "R11 irq unmasked", irq, 1);
      repeat (3) @(negedge clk);
      chk(err_flag, "R11 flag sticky", err_flag, 1);
      err_clear_t = 1;
      @(negedge clk);
      err_clear_t = 0;
      chk(!err_flag && !irq, "R11 clear", {err_flag, irq}, 0);

      // R11 set and clear in the same cycle: set wins
      clear_on_last = 1;
      p = predict(model_crc, 32'h3200, 3, 2'd1);
      run(32'h3200, 3, 2'd1, 0, 1, p ^ 32'h1, 0);
      chk(err_flag, "R11 set beats clear", err_flag, 1);
      err_clear_t = 1;
      @(negedge clk);
      err_clear_t = 0;
      chk(!err_flag, "R11 clear after collision", err_flag, 0);

      // R4 width code 3 behaves as word, with larger divider (R6)
      run(32'h4000, 4, 2'd3, 7, 0, 0, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule